// File: doc/BRIEF.md
# Packed Dual-Halfword Signed Saturating Adder

This block takes two 32-bit words and treats each as a pair of signed 16-bit values. The two lower halves are added together, and so are the two upper halves. Each sum is found at full precision and then limited to the signed 16-bit range. The two limited sums are packed back into one 32-bit word. No carry passes between the halves.

A one-cycle strobe qualifies the operands. The packed result and a strobe come back one clock later. Each lane also reports whether it was clamped on that operation. This per-lane indication is for observation only. Nothing accumulates: the block keeps no sticky overflow status, so every valid operation overwrites the indication. When the input strobe is low, the registered outputs keep their last values.

Top module: `dh_satadd_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0, `result` is 0x00000000 and `lane_sat` is 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R3: For a valid operation, `result[15:0]` equals the signed sum of `op_a[15:0]` and `op_b[15:0]`, each read as two's complement, when that sum lies in -32768..32767.
- R4: For a valid operation, `result[31:16]` equals the signed sum of `op_a[31:16]` and `op_b[31:16]` under the same rule, with no carry or borrow from the lower lane.
- R5: A lane sum above 32767 gives 0x7FFF in that lane. For example, 0x7FFF + 0x0001 gives 0x7FFF.
- R6: A lane sum below -32768 gives 0x8000 in that lane. For example, 0x8000 + 0xFFFF gives 0x8000.
- R7: `lane_sat[0]` refers to bits 15:0 and `lane_sat[1]` to bits 31:16. Each bit is 1 after a valid operation exactly when that lane was clamped.
- R8: When `in_valid` is low, `result` and `lane_sat` keep their previous values.
- R9: Saturation is not sticky. A valid operation that clamps no lane leaves `lane_sat` at 0, whatever earlier operations did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the operands for this cycle |
| op_a | input | 32 | First packed operand, two signed halfwords |
| op_b | input | 32 | Second packed operand, two signed halfwords |
| out_valid | output | 1 | High one cycle after a valid operation |
| result | output | 32 | Packed clamped sums; lower lane in bits 15:0 |
| lane_sat | output | 2 | Per-lane clamp indication for the last operation |

## Verification
Several groups of operands are used. In-range sums of mixed sign show that each half is read as signed. A lower lane that wraps through 0xFFFF + 0x0001 shows whether any carry leaks into the upper lane. Sums just past each limit are applied, with the two lanes overflowing in opposite directions in one word, which separates the positive clamp from the negative clamp and shows that each lane gets its own indication bit. A clamping operation followed by a clean one, and idle cycles between operations, tell a per-operation indication from a sticky one and a held result from one that drifts.

// File: rtl/dh_satadd_pkg.sv
package dh_satadd_pkg;

  localparam int unsigned DH_LANE_W = 16;
  localparam int unsigned DH_LANES  = 2;

  typedef struct packed {
    logic                 sat;
    logic [DH_LANE_W-1:0] val;
  } dh_lane_res_t;

  // Signed add with one guard bit, then clamp to the lane range.
  function automatic dh_lane_res_t dh_sat_add(input logic [DH_LANE_W-1:0] a,
                                              input logic [DH_LANE_W-1:0] b);
    logic [DH_LANE_W:0] wide;
    dh_lane_res_t       r;
    wide = {a[DH_LANE_W-1], a} + {b[DH_LANE_W-1], b};
    r.sat = wide[DH_LANE_W] ^ wide[DH_LANE_W-1];
    if (!r.sat)
      r.val = wide[DH_LANE_W-1:0];
    else if (wide[DH_LANE_W])
      r.val = {1'b1, {(DH_LANE_W-1){1'b0}}};
    else
      r.val = {1'b0, {(DH_LANE_W-1){1'b1}}};
    return r;
  endfunction

endpackage

// File: rtl/dh_satadd_lane.sv
module dh_satadd_lane
  import dh_satadd_pkg::*;
(
  input  logic [DH_LANE_W-1:0] a_i,
  input  logic [DH_LANE_W-1:0] b_i,
  output logic [DH_LANE_W-1:0] sum_o,
  output logic                 sat_o
);

  dh_lane_res_t res;

  always_comb begin
    res   = dh_sat_add(a_i, b_i);
    sum_o = res.val;
    sat_o = res.sat;
  end

  // R5/R6: a clamped lane always reports one of the two range limits.
  always_comb begin
    if (sat_o) begin
      a_r7_sat_at_limit: assert (sum_o[DH_LANE_W-2:0] == {(DH_LANE_W-1){~sum_o[DH_LANE_W-1]}});
    end
  end

endmodule

// File: rtl/dh_satadd_outreg.sv
module dh_satadd_outreg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FLAG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic [FLAG_W-1:0] flag_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      flag_o <= '0;
    end else begin
      vld_o <= load_i;
      if (load_i) begin
        data_o <= data_i;
        flag_o <= flag_i;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> vld_o);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> !vld_o);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(data_o) && $stable(flag_o)));

endmodule

// File: rtl/dh_satadd_top.sv
module dh_satadd_top
  import dh_satadd_pkg::*;
#(
  parameter int unsigned LANE_W = DH_LANE_W,
  parameter int unsigned LANES  = DH_LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANE_W*LANES-1:0] op_a,
  input  logic [LANE_W*LANES-1:0] op_b,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] result,
  output logic [LANES-1:0]        lane_sat
);

  localparam int unsigned WORD_W = LANE_W * LANES;

  logic [WORD_W-1:0] lane_sum_w;
  logic [LANES-1:0]  lane_sat_w;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dh_satadd_lane u_lane (
      .a_i   (op_a[g*LANE_W +: LANE_W]),
      .b_i   (op_b[g*LANE_W +: LANE_W]),
      .sum_o (lane_sum_w[g*LANE_W +: LANE_W]),
      .sat_o (lane_sat_w[g])
    );

    // R5/R6 at the ports: a flagged lane sits at one of the two limits.
    a_r7_flag_means_limit: assert property (@(posedge clk) disable iff (!rst_n)
      lane_sat[g] |-> (result[g*LANE_W +: LANE_W] == {1'b0, {(LANE_W-1){1'b1}}} ||
                       result[g*LANE_W +: LANE_W] == {1'b1, {(LANE_W-1){1'b0}}}));
  end

  dh_satadd_outreg #(
    .DATA_W (WORD_W),
    .FLAG_W (LANES)
  ) u_outreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (in_valid),
    .data_i (lane_sum_w),
    .flag_i (lane_sat_w),
    .vld_o  (out_valid),
    .data_o (result),
    .flag_o (lane_sat)
  );

  // R9: an operation that clamps no lane leaves no indication behind.
  a_r9_not_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sat_w == '0) |=> (lane_sat == '0));

endmodule

// File: tb/dh_satadd_top_tb_top.sv
module dh_satadd_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [1:0]  lane_sat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dh_satadd_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .lane_sat  (lane_sat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model: clamp a signed 16+16 sum independently of the design.
  function automatic logic [16:0] model_lane(input logic [15:0] a, input logic [15:0] b);
    int s;
    s = int'($signed(a)) + int'($signed(b));
    if (s > 32767)  return {1'b1, 16'h7FFF};
    if (s < -32768) return {1'b1, 16'h8000};
    return {1'b0, s[15:0]};
  endfunction

  // One valid cycle, then sample after the registering edge.
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b);
    logic [16:0] lo, hi;
    lo = model_lane(a[15:0], b[15:0]);
    hi = model_lane(a[31:16], b[31:16]);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R2 valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " R3 low lane"}, {16'd0, result[15:0]}, {16'd0, lo[15:0]});
    check({req, " R4 high lane"}, {16'd0, result[31:16]}, {16'd0, hi[15:0]});
    check({req, " R7 flags"}, {30'd0, lane_sat}, {30'd0, hi[16], lo[16]});
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 flags", {30'd0, lane_sat}, 32'd0);
  endtask

  task automatic t_in_range;
    run_op("R3 mixed sign", 32'h0005_FFFD, 32'hFFF0_0002);
    check("R3 low value", {16'd0, result[15:0]}, 32'h0000_FFFF);
    check("R4 high value", {16'd0, result[31:16]}, 32'h0000_FFF5);
  endtask

  task automatic t_no_carry;
    run_op("R4 lane isolation", 32'h1234_FFFF, 32'h0000_0001);
    check("R4 no carry", result, 32'h1234_0000);
  endtask

  task automatic t_pos_clamp;
    run_op("R5 positive", 32'h7FFF_7FFF, 32'h0001_0001);
    check("R5 value", result, 32'h7FFF_7FFF);
    check("R5 flags", {30'd0, lane_sat}, 32'd3);
  endtask

  task automatic t_neg_clamp;
    run_op("R6 negative", 32'h8000_8000, 32'hFFFF_FFFF);
    check("R6 value", result, 32'h8000_8000);
  endtask

  task automatic t_split;
    run_op("R7 split", 32'h8000_7000, 32'h8000_2000);
    check("R7 split value", result, 32'h8000_7FFF);
    check("R7 split flags", {30'd0, lane_sat}, 32'd3);
    run_op("R7 low only", 32'h0001_7000, 32'h0001_2000);
    check("R7 low only flags", {30'd0, lane_sat}, 32'd1);
  endtask

  task automatic t_hold;
    logic [31:0] keep;
    run_op("R8 setup", 32'h4000_4000, 32'h4000_0001);
    keep = result;
    @(negedge clk);
    op_a = 32'h1111_1111; op_b = 32'h2222_2222;
    repeat (3) @(negedge clk);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R8 held result", result, keep);
    check("R8 held flags", {30'd0, lane_sat}, 32'd2);
  endtask

  task automatic t_not_sticky;
    run_op("R9 clamp", 32'h7FFF_8000, 32'h7FFF_8000);
    run_op("R9 clean", 32'h0001_0002, 32'h0003_0004);
    check("R9 flags cleared", {30'd0, lane_sat}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_in_range;
    t_no_carry;
    t_pos_clamp;
    t_neg_clamp;
    t_split;
    t_hold;
    t_not_sticky;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule